// File: doc/BRIEF.md
# Register-Mapped SPI Host Controller

This block is a single-word SPI master that software drives through a small 32-bit register window. A configuration register picks the clock idle level, the sampling phase, bit order, word length (4 to 16 bits or 32 bits) and a two-stage bit clock divider. Writing the transmit register starts one word on SCK and MOSI while MISO is sampled. At the end of the word, the received bits appear right-justified in the receive register. A sticky "word received" event is then raised.

Two event flags, "word received" and "transmitter free", can each be unmasked onto a level interrupt. Chip selects are not part of this block. Software drives them from outside around each transfer.

The shift engine is a three-state machine:

| State | Meaning |
|---|---|
| `ST_OFF` | Controller disabled; SCK held at its idle level. |
| `ST_IDLE` | Enabled and waiting for a transmit write. |
| `ST_SHIFT` | A word is on the wire. |

| Transition | Condition |
|---|---|
| OFF→IDLE | The enable bit is set. |
| IDLE→SHIFT | A transmit write arrives in master mode. |
| SHIFT→IDLE | The last clock edge of the word. |
| IDLE→OFF, SHIFT→OFF | The enable bit is cleared. |

Top module: `spi_host_ctrl`

## Requirements
- R1: Register byte offsets are configuration 0x20, events 0x24, mask 0x28, command 0x2C (reads zero), transmit 0x30 and receive 0x34. After reset, configuration, mask and receive read 0. Events read 0x100 (only the free flag), and irq and sck are 0.
- R2: A transmit write starts a word only when configuration bit 24 (enable) and bit 25 (master) are both 1. Otherwise the write is ignored: no SCK edge and no received event.
- R3: Configuration bits 23:20 hold the word length minus one, with 0 meaning 32 bits. Exactly that many bits are sent and received.
- R4: One SCK half period lasts 2×(PM+1) system cycles, where PM is configuration bits 19:16. Setting bit 27 multiplies this by 16. A word of n bits completes exactly 2·n half periods after the clock edge that accepts the transmit write.
- R5: Configuration bit 29 sets the SCK idle level. SCK rests at that level whenever no word is shifting, including while disabled.
- R6: With configuration bit 28 clear, MISO is sampled on the odd-numbered SCK transitions (1st, 3rd, ...) and MOSI changes on the others. With bit 28 set, the roles are swapped.
- R7: With configuration bit 26 set, the word goes most significant bit first. With it clear, bit 0 goes first. Received bits are placed in the same order.
- R8: The received word is right-justified in the receive register, and bits above the word length read 0.
- R9: Event bit 9 (word received) sets at the completing edge and stays set until a write with bit 9 at 1 to the event register. Writing 0 there leaves it set.
- R10: Event bit 8 (transmitter free) reads 0 while a word is shifting and 1 otherwise. Writes do not change it.
- R11: irq is high exactly when some event bit (9 or 8) and the same bit of the mask register (0x28) are both 1.
- R12: A transmit write while a word is shifting is ignored. The word on the wire and its completion time are unchanged.
- R13: Clearing the enable bit mid-word aborts it. SCK returns to idle, the free flag returns to 1, no received event is raised, and the next enabled transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt |
| sck | output | 1 | SPI bit clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The transmit write is captured at clock edge k. The received word, event bit 9 and the return of the free flag then all appear at edge k + 2·n·half, where half = 2·(PM+1)·(16 if bit 27). The bench reads the event register at the falling edge just before that edge, expecting bit 9 = 0 and bit 8 = 0, and again just after it, expecting both 1. This pins the completion cycle exactly rather than polling. Register reads are combinational, so each is sampled half a cycle after the address changes. A bench SPI slave reacts to every SCK transition and independently tracks which transition is a sample edge.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int WORD_W = 32;
    localparam int LEN_W  = 4;
    localparam int PM_W   = 4;
    localparam int CFG_LO = 16;
    localparam int CFG_W  = 14;

    localparam logic [7:0] OFS_CFG   = 8'h20;
    localparam logic [7:0] OFS_EVENT = 8'h24;
    localparam logic [7:0] OFS_MASK  = 8'h28;
    localparam logic [7:0] OFS_CMD   = 8'h2C;
    localparam logic [7:0] OFS_TX    = 8'h30;
    localparam logic [7:0] OFS_RX    = 8'h34;

    localparam int BIT_EN     = 24;
    localparam int BIT_MASTER = 25;
    localparam int BIT_CPOL   = 29;
    localparam int EV_RXNE    = 9;
    localparam int EV_TXNF    = 8;

    typedef enum logic [1:0] {ST_OFF, ST_IDLE, ST_SHIFT} eng_state_t;

    // field order matches bits 29 down to 16 of the configuration register
    typedef struct packed {
        logic             idle_high;
        logic             late_phase;
        logic             slow;
        logic             msb_first;
        logic             master;
        logic             enable;
        logic [LEN_W-1:0] len_code;
        logic [PM_W-1:0]  pm;
    } cfg_t;
endpackage

// File: rtl/spi_host_prescale.sv
module spi_host_prescale
    import spi_host_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PM_W-1:0] pm,
    input  logic            slow,
    output logic            tick
);
    localparam int CNT_W = $clog2(2 * (1 << PM_W) * SLOW_DIV);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        int unsigned span;
        span = (int'(pm) + 1) * 2;
        if (slow) span = span * SLOW_DIV;
        half_m1 = CNT_W'(span - 1);
    end

    assign tick = run && (cnt == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              msb_first,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int EDGE_W = IDX_W + 2;

    eng_state_t        state, state_nx;
    logic [IDX_W:0]    nbits;
    logic [IDX_W-1:0]  top_idx;
    logic [EDGE_W-1:0] edge_cnt;
    logic              sck_ph;
    logic [WORD_W-1:0] tx_sh, rx_sh, rx_upd;
    logic              last_edge, sample_now, shift_now;

    always_comb begin
        nbits = (len_code == '0) ? (IDX_W+1)'(WORD_W) : (IDX_W+1)'(len_code) + 1'b1;
        top_idx = IDX_W'(nbits - 1'b1);
    end

    assign last_edge  = (edge_cnt == ((EDGE_W'(nbits) << 1) - EDGE_W'(1)));
    assign sample_now = tick && (edge_cnt[0] == cpha);
    assign shift_now  = tick && !sample_now && (edge_cnt != '0);
    assign busy       = (state == ST_SHIFT);
    assign done       = busy && enable && tick && last_edge;
    assign sck        = cpol ^ sck_ph;
    assign mosi       = msb_first ? tx_sh[top_idx] : tx_sh[0];

    always_comb begin
        rx_upd = rx_sh;
        if (sample_now) begin
            if (msb_first) begin
                rx_upd = {rx_sh[WORD_W-2:0], miso};
            end else begin
                rx_upd = rx_sh >> 1;
                rx_upd[top_idx] = miso;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // transitions: OFF->IDLE, IDLE->SHIFT, SHIFT->IDLE, IDLE/SHIFT->OFF
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (enable) state_nx = ST_IDLE;
            ST_IDLE:  if (!enable) state_nx = ST_OFF;
                      else if (start) state_nx = ST_SHIFT;
            ST_SHIFT: if (!enable) state_nx = ST_OFF;
                      else if (tick && last_edge) state_nx = ST_IDLE;
            default:  state_nx = ST_OFF;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_ph   <= 1'b0;
            edge_cnt <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_word  <= '0;
        end else begin
            unique case (state)
                ST_SHIFT: begin
                    if (!enable) begin
                        sck_ph   <= 1'b0;
                        edge_cnt <= '0;
                    end else if (tick) begin
                        sck_ph   <= ~sck_ph;
                        edge_cnt <= edge_cnt + 1'b1;
                        rx_sh    <= rx_upd;
                        if (shift_now)
                            tx_sh <= msb_first ? (tx_sh << 1) : (tx_sh >> 1);
                        if (last_edge)
                            rx_word <= rx_upd;
                    end
                end
                ST_IDLE: begin
                    if (enable && start) begin
                        tx_sh    <= tx_word;
                        rx_sh    <= '0;
                        edge_cnt <= '0;
                        sck_ph   <= 1'b0;
                    end
                end
                default: begin
                    sck_ph   <= 1'b0;
                    edge_cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    cfg_t              cfg_q;
    logic              ne_q;
    logic [1:0]        mask_q;
    logic              busy, done, tick;
    logic [WORD_W-1:0] rx_word;
    logic              wr_cfg, wr_event, wr_mask, wr_tx;

    assign wr_cfg   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CFG));
    assign wr_event = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_EVENT));
    assign wr_mask  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
    assign wr_tx    = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_TX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            ne_q   <= 1'b0;
            mask_q <= '0;
        end else begin
            if (wr_cfg)  cfg_q  <= cfg_t'(bus_wdata[CFG_LO+CFG_W-1:CFG_LO]);
            if (wr_mask) mask_q <= bus_wdata[EV_RXNE:EV_TXNF];
            if (done)                             ne_q <= 1'b1;
            else if (wr_event && bus_wdata[EV_RXNE]) ne_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CFG):   bus_rdata[CFG_LO+CFG_W-1:CFG_LO] = cfg_q;
            ADDR_W'(OFS_EVENT): begin
                bus_rdata[EV_RXNE] = ne_q;
                bus_rdata[EV_TXNF] = !busy;
            end
            ADDR_W'(OFS_MASK):  bus_rdata[EV_RXNE:EV_TXNF] = mask_q;
            ADDR_W'(OFS_RX):    bus_rdata = rx_word;
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = (ne_q && mask_q[1]) || (!busy && mask_q[0]);

    spi_host_prescale #(.SLOW_DIV(SLOW_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .pm    (cfg_q.pm),
        .slow  (cfg_q.slow),
        .tick  (tick)
    );

    spi_host_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_q.enable),
        .start     (wr_tx && cfg_q.master),
        .cpol      (cfg_q.idle_high),
        .cpha      (cfg_q.late_phase),
        .msb_first (cfg_q.msb_first),
        .len_code  (cfg_q.len_code),
        .tx_word   (bus_wdata),
        .tick      (tick),
        .miso      (miso),
        .busy      (busy),
        .done      (done),
        .sck       (sck),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );
endmodule

// File: rtl/spi_host_checker.sv
module spi_host_checker
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              ne,
    input logic [CFG_W-1:0]  cfg_bits,
    input logic [1:0]        mask,
    input logic              irq,
    input logic              sck,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata
);
    logic en, master, idle_lvl, tx_req, clr_ne;
    assign en       = cfg_bits[BIT_EN - CFG_LO];
    assign master   = cfg_bits[BIT_MASTER - CFG_LO];
    assign idle_lvl = cfg_bits[BIT_CPOL - CFG_LO];
    assign tx_req   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_TX));
    assign clr_ne   = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_EVENT)) && bus_wdata[EV_RXNE];

    AST_START_NEEDS_EN_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_req && en && master)); // R2
    AST_SCK_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == idle_lvl)); // R5
    AST_RXNE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ne) |-> $past(busy)); // R9
    AST_RXNE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ne && !clr_ne) |=> ne); // R9
    AST_FREE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_addr == ADDR_W'(OFS_EVENT)) |-> !bus_rdata[EV_TXNF]); // R10
    AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq); // R11
    AST_ABORT_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |=> !busy); // R13
endmodule

bind spi_host_ctrl spi_host_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .ne        (ne_q),
    .cfg_bits  (cfg_q),
    .mask      (mask_q),
    .irq       (irq),
    .sck       (sck),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
);

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, sck, mosi;
    logic        miso;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    // bench SPI slave
    logic        slv_load = 1'b0;
    logic        slv_arm = 1'b0;
    logic        slv_cpha = 1'b0;
    logic        slv_msb = 1'b1;
    int          slv_n = 8;
    logic [31:0] slv_word = 32'h0;
    logic [31:0] slv_got;
    int          slv_e, slv_in, slv_out, slv_edges;

    initial begin
        miso = 1'b0;
        slv_got = 32'h0;
        slv_e = 0; slv_in = 0; slv_out = 0; slv_edges = 0;
    end

    always @(posedge slv_load or sck) begin
        if (slv_load) begin
            slv_e = 0; slv_in = 0; slv_out = 0; slv_got = 32'h0; slv_edges = 0;
            miso = slv_word[slv_msb ? slv_n - 1 : 0];
        end else begin
            slv_edges = slv_edges + 1;
            if (slv_arm) begin
                if ((slv_e % 2) == int'(slv_cpha)) begin
                    if (slv_in < slv_n) slv_got[slv_msb ? slv_n - 1 - slv_in : slv_in] = mosi;
                    slv_in = slv_in + 1;
                end else if (slv_e != 0) begin
                    slv_out = slv_out + 1;
                    if (slv_out < slv_n) miso = slv_word[slv_msb ? slv_n - 1 - slv_out : slv_out];
                end
                slv_e = slv_e + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_cfg(input logic en, input logic mst, input logic cpol,
            input logic cpha, input logic slow, input logic msb, input logic [3:0] len, input logic [3:0] pm);
        return {2'b00, cpol, cpha, slow, msb, mst, en, len, pm, 16'h0000};
    endfunction

    task automatic slave_prep(input logic cpha, input logic msb, input int n, input logic [31:0] w);
        slv_cpha = cpha; slv_msb = msb; slv_n = n; slv_word = w;
        slv_load = 1'b1; #0.5; slv_load = 1'b0;
    endtask

    // full transfer with exact completion timing
    task automatic run_xfer(input string req, input logic cpol, input logic cpha, input logic msb,
            input logic slow, input logic [3:0] len, input logic [3:0] pm,
            input logic [31:0] txw, input logic [31:0] sw);
        int n, half;
        logic [31:0] msk, ev, rx;
        n = (len == 4'd0) ? 32 : int'(len) + 1;
        half = 2 * (int'(pm) + 1) * (slow ? 16 : 1);
        msk = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        bus_write(8'h20, mk_cfg(1'b1, 1'b1, cpol, cpha, slow, msb, len, pm));
        slave_prep(cpha, msb, n, sw);
        slv_arm = 1'b1;
        bus_write(8'h30, txw);
        repeat (2 * n * half - 1) @(negedge clk);
        bus_read(8'h24, ev);
        chk({req, " R4 R10"}, "event one cycle before end", ev, 32'h0000_0000);
        @(negedge clk);
        bus_read(8'h24, ev);
        chk({req, " R4 R9"}, "event at end", ev, 32'h0000_0300);
        bus_read(8'h34, rx);
        chk({req, " R3 R6 R7 R8"}, "receive word", rx, sw & msk);
        chk({req, " R3 R6 R7"}, "slave got", slv_got, txw & msk);
        chk({req, " R5"}, "sck idle after word", {31'b0, sck}, {31'b0, cpol});
        slv_arm = 1'b0;
        bus_write(8'h24, 32'h0000_0200);
        bus_read(8'h24, ev);
        chk({req, " R9"}, "event after clear", ev, 32'h0000_0100);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(8'h20, d); chk("R1", "cfg reset", d, 32'h0);
        bus_read(8'h24, d); chk("R1", "event reset", d, 32'h0000_0100);
        bus_read(8'h28, d); chk("R1", "mask reset", d, 32'h0);
        bus_read(8'h2C, d); chk("R1", "command reads zero", d, 32'h0);
        bus_read(8'h34, d); chk("R1", "receive reset", d, 32'h0);
        chk("R1", "irq reset", {31'b0, irq}, 32'h0);
        chk("R1", "sck reset", {31'b0, sck}, 32'h0);
    endtask

    task automatic t_not_started(input string req, input logic en, input logic mst);
        logic [31:0] d;
        int e0;
        bus_write(8'h20, mk_cfg(en, mst, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7, 4'd0));
        chk({req, " R5"}, "sck idle high while not running", {31'b0, sck}, 32'h1);
        e0 = slv_edges;
        bus_write(8'h30, 32'h0000_00A5);
        repeat (80) @(negedge clk);
        bus_read(8'h24, d);
        chk(req, "no event for ignored start", d, 32'h0000_0100);
        chk(req, "no sck edges", slv_edges, e0);
    endtask

    task automatic t_busy_write;
        logic [31:0] ev;
        bus_write(8'h20, mk_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7, 4'd0));
        slave_prep(1'b0, 1'b1, 8, 32'h0000_003C);
        slv_arm = 1'b1;
        bus_write(8'h30, 32'h0000_0081);
        bus_write(8'h30, 32'h0000_00FF);
        repeat (32 - 2 - 1) @(negedge clk);
        bus_read(8'h24, ev);
        chk("R12", "still busy before original end", ev, 32'h0);
        @(negedge clk);
        bus_read(8'h24, ev);
        chk("R12", "done at original time", ev, 32'h0000_0300);
        chk("R12", "slave got first word", slv_got, 32'h0000_0081);
        slv_arm = 1'b0;
        bus_write(8'h24, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq;
        logic [31:0] ev;
        bus_write(8'h28, 32'h0000_0100);
        chk("R11", "irq on free flag when idle", {31'b0, irq}, 32'h1);
        bus_write(8'h20, mk_cfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7, 4'd0));
        bus_write(8'h30, 32'h0000_0011);
        chk("R11", "irq low while busy", {31'b0, irq}, 32'h0);
        repeat (40) @(negedge clk);
        chk("R11", "irq back when free", {31'b0, irq}, 32'h1);
        bus_write(8'h28, 32'h0000_0200);
        chk("R11", "irq on received event", {31'b0, irq}, 32'h1);
        bus_write(8'h24, 32'h0000_0000);
        bus_read(8'h24, ev);
        chk("R9", "write zero keeps event", ev, 32'h0000_0300);
        bus_write(8'h24, 32'h0000_0100);
        bus_read(8'h24, ev);
        chk("R10", "free flag unaffected by write", ev, 32'h0000_0300);
        bus_write(8'h24, 32'h0000_0200);
        chk("R11", "irq low after clear", {31'b0, irq}, 32'h0);
        bus_write(8'h28, 32'h0);
    endtask

    task automatic t_abort;
        logic [31:0] ev;
        bus_write(8'h20, mk_cfg(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 4'd1));
        bus_write(8'h30, 32'h0000_1234);
        repeat (11) @(negedge clk);
        bus_write(8'h20, mk_cfg(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd15, 4'd1));
        @(negedge clk);
        bus_read(8'h24, ev);
        chk("R13", "aborted: free, no event", ev, 32'h0000_0100);
        chk("R13", "aborted: sck idle", {31'b0, sck}, 32'h1);
        repeat (200) @(negedge clk);
        bus_read(8'h24, ev);
        chk("R13", "no late event", ev, 32'h0000_0100);
        run_xfer("R13", 1'b1, 1'b0, 1'b1, 1'b0, 4'd15, 4'd1, 32'h0000_BEEF, 32'h0000_7A53);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_xfer("mode0 msb 8b", 1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 4'd0, 32'h0000_00C3, 32'h0000_005A);
        run_xfer("mode3 lsb 8b", 1'b1, 1'b1, 1'b0, 1'b0, 4'd7, 4'd2, 32'h0000_0096, 32'h0000_00E1);
        run_xfer("cpol1 cpha0 16b", 1'b1, 1'b0, 1'b1, 1'b0, 4'd15, 4'd0, 32'h0000_A55A, 32'h0000_3CC3);
        run_xfer("cpha1 lsb 16b", 1'b0, 1'b1, 1'b0, 1'b0, 4'd15, 4'd0, 32'h0000_8001, 32'h0000_1F2E);
        run_xfer("32b slow", 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd1, 32'hDEAD_BEEF, 32'h1357_9BDF);
        run_xfer("4b upper zero", 1'b0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd0, 32'hFFFF_FFF9, 32'hFFFF_FFF6);
        run_xfer("4b lsb", 1'b1, 1'b1, 1'b0, 1'b0, 4'd3, 4'd0, 32'h0000_0001, 32'h0000_0008);
        t_not_started("R2 disabled", 1'b0, 1'b1);
        t_not_started("R2 not master", 1'b1, 1'b0);
        t_busy_write();
        t_irq();
        t_abort();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule